// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block keeps two banks of programmable translation windows, one for traffic entering the chip (inbound) and one for traffic leaving it (outbound). Each bank holds `NUM_WIN` windows. Software does not address windows directly. It first writes a selector register that names a direction and a window index. A shared group of window registers then reads and writes the fields of the selected window.

Each window has a base, a limit, a target and a type. The window registers are a staging copy. The translation logic only uses a window's settings after software writes that window's second control register, which also carries the enable bit. For each request address and direction, the block searches the enabled windows of that direction. The search and translation take one registered pipeline stage with a valid/ready handshake. The result is one of three things:

- a translated memory address;
- a configuration-access descriptor (bus, device/function, register offset);
- a miss.

Top module: `addr_window_xlate`

## Requirements
- R1: The selector register sits at offset 0x900. Write bit 31 picks the inbound bank (1) or the outbound bank (0), and bits 3:0 pick the window index. A read returns the direction in bit 31, the index in bits 3:0, and zero in every other bit.
- R2: The shared window registers are at these offsets: 0x904 control1 (type in bits 4:0), 0x908 control2 (enable in bit 31), 0x90C base low, 0x910 base high, 0x914 limit, 0x918 target low and 0x91C target high. Reads return the staged fields of the selected window. When the selected index is `NUM_WIN` or more, writes are ignored and reads return zero.
- R3: A write to control2 commits the selected window's staged base, limit, target and type, together with the new enable bit. Writes to the other window registers do not change translation until that commit.
- R4: After reset, every window has base 0, target 0, limit 0xFFFFFFFF and type 0 (memory), and is disabled. The one exception is inbound window 0, which is enabled, both staged and committed.
- R5: A committed, enabled window of the request's direction matches address A when base <= A <= {base[63:32], limit}. The 32-bit limit therefore shares the upper half of the base.
- R6: When several windows match, the lowest index wins and its index appears on `rsp_win`. With no match, `rsp_miss` is 1, `rsp_cfg` is 0 and `rsp_addr` is 0.
- R7: A window with type 0 is a memory window. The output address is target + (A - base).
- R8: A window with a non-zero type is a configuration window. The bus is target[31:23+1], i.e. target bits 31:24, and the device/function is target bits 23:16. `rsp_addr` carries the register offset, which is A modulo 2^`CFG_OFF_W`.
- R9: A request is accepted when `req_valid` and `req_ready` are both high, and its result appears on the next cycle with `rsp_valid`. `req_ready` is high when the output is empty or `rsp_ready` is high. A result that is not taken stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_inbound | input | 1 | Request direction, 1 = inbound |
| req_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_miss | output | 1 | No window matched |
| rsp_cfg | output | 1 | Result is a configuration access |
| rsp_win | output | clog2(NUM_WIN) | Index of the matching window |
| rsp_addr | output | ADDR_W | Translated address, or configuration register offset |
| rsp_bus | output | 8 | Configuration bus number |
| rsp_devfn | output | 8 | Configuration device/function |

## Verification
The assertions run on every cycle and check the following:
- the handshake: an accepted request always yields a result, and a stalled result holds still;
- that a miss carries no address and no configuration flag;
- that a configuration result never carries an offset wider than the configuration space;
- the reserved bits of the selector readback.

Only the bench scenarios can show the arithmetic of translation, the window boundaries, lowest-index priority, the upper-base extension of the limit, the reset window set and the staging rule. Each of these depends on what software programmed earlier. The bench sweeps a four-window configuration across the full programmed range and compares every result with a value it works out itself.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int NUM_WIN   = 16,
  parameter int ADDR_W    = 64,
  parameter int CFG_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_inbound,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_miss,
  output logic                 rsp_cfg,
  output logic [(NUM_WIN>1 ? $clog2(NUM_WIN) : 1)-1:0] rsp_win,
  output logic [ADDR_W-1:0]    rsp_addr,
  output logic [7:0]           rsp_bus,
  output logic [7:0]           rsp_devfn
);
  localparam int WIN_W  = NUM_WIN > 1 ? $clog2(NUM_WIN) : 1;
  localparam int SLOTS  = 2 * NUM_WIN;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [11:0] OFF_SEL   = 12'h900;
  localparam logic [11:0] OFF_CTL1  = 12'h904;
  localparam logic [11:0] OFF_CTL2  = 12'h908;
  localparam logic [11:0] OFF_BLO   = 12'h90C;
  localparam logic [11:0] OFF_BHI   = 12'h910;
  localparam logic [11:0] OFF_LIM   = 12'h914;
  localparam logic [11:0] OFF_TLO   = 12'h918;
  localparam logic [11:0] OFF_THI   = 12'h91C;

  logic        sel_in;
  logic [3:0]  sel_idx;
  logic        sel_ok;
  logic [SLOT_W-1:0] sel;

  logic [63:0] st_base [SLOTS];
  logic [63:0] st_tgt  [SLOTS];
  logic [31:0] st_lim  [SLOTS];
  logic [31:0] st_ctl1 [SLOTS];
  logic        st_en   [SLOTS];

  logic [63:0] cm_base [SLOTS];
  logic [63:0] cm_tgt  [SLOTS];
  logic [31:0] cm_lim  [SLOTS];
  logic        cm_cfg  [SLOTS];
  logic        cm_en   [SLOTS];

  assign sel_ok = 32'(sel_idx) < 32'(NUM_WIN);
  assign sel    = (sel_in ? SLOT_W'(NUM_WIN) : SLOT_W'(0)) + SLOT_W'(sel_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_in  <= 1'b0;
      sel_idx <= 4'd0;
      for (int i = 0; i < SLOTS; i++) begin
        st_base[i] <= '0;
        st_tgt[i]  <= '0;
        st_lim[i]  <= 32'hFFFF_FFFF;
        st_ctl1[i] <= '0;
        st_en[i]   <= (i == NUM_WIN);
        cm_base[i] <= '0;
        cm_tgt[i]  <= '0;
        cm_lim[i]  <= 32'hFFFF_FFFF;
        cm_cfg[i]  <= 1'b0;
        cm_en[i]   <= (i == NUM_WIN);
      end
    end else if (reg_we) begin
      if (reg_addr == OFF_SEL) begin
        sel_in  <= reg_wdata[31];
        sel_idx <= reg_wdata[3:0];
      end else if (sel_ok) begin
        case (reg_addr)
          OFF_CTL1: st_ctl1[sel] <= reg_wdata;
          OFF_CTL2: begin
            st_en[sel]   <= reg_wdata[31];
            cm_en[sel]   <= reg_wdata[31];
            cm_base[sel] <= st_base[sel];
            cm_tgt[sel]  <= st_tgt[sel];
            cm_lim[sel]  <= st_lim[sel];
            cm_cfg[sel]  <= |st_ctl1[sel][4:0];
          end
          OFF_BLO:  st_base[sel][31:0]  <= reg_wdata;
          OFF_BHI:  st_base[sel][63:32] <= reg_wdata;
          OFF_LIM:  st_lim[sel]         <= reg_wdata;
          OFF_TLO:  st_tgt[sel][31:0]   <= reg_wdata;
          OFF_THI:  st_tgt[sel][63:32]  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_SEL)
      reg_rdata = {sel_in, 27'd0, sel_idx};
    else if (sel_ok) begin
      case (reg_addr)
        OFF_CTL1: reg_rdata = st_ctl1[sel];
        OFF_CTL2: reg_rdata = {st_en[sel], 31'd0};
        OFF_BLO:  reg_rdata = st_base[sel][31:0];
        OFF_BHI:  reg_rdata = st_base[sel][63:32];
        OFF_LIM:  reg_rdata = st_lim[sel];
        OFF_TLO:  reg_rdata = st_tgt[sel][31:0];
        OFF_THI:  reg_rdata = st_tgt[sel][63:32];
        default:  reg_rdata = '0;
      endcase
    end
  end

  logic [63:0] a64;
  logic [NUM_WIN-1:0] hit;
  assign a64 = 64'(req_addr);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam int SI = g;
    localparam int SO = NUM_WIN + g;
    logic [63:0] b;
    logic [31:0] l;
    logic        e;
    assign b = req_inbound ? cm_base[SO] : cm_base[SI];
    assign l = req_inbound ? cm_lim[SO]  : cm_lim[SI];
    assign e = req_inbound ? cm_en[SO]   : cm_en[SI];
    assign hit[g] = e && (a64 >= b) && (a64 <= {b[63:32], l});
  end

  logic             found;
  logic [WIN_W-1:0] win;
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (hit[i]) begin
        found = 1'b1;
        win   = WIN_W'(i);
      end
  end

  logic [SLOT_W-1:0] ws;
  logic [63:0]       w_base, w_tgt, mem_addr;
  logic              w_cfg;
  assign ws       = (req_inbound ? SLOT_W'(NUM_WIN) : SLOT_W'(0)) + SLOT_W'(win);
  assign w_base   = cm_base[ws];
  assign w_tgt    = cm_tgt[ws];
  assign w_cfg    = cm_cfg[ws];
  assign mem_addr = w_tgt + (a64 - w_base);

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_cfg   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
      rsp_bus   <= '0;
      rsp_devfn <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_miss  <= !found;
        rsp_cfg   <= found && w_cfg;
        rsp_win   <= win;
        rsp_bus   <= (found && w_cfg) ? w_tgt[31:24] : 8'd0;
        rsp_devfn <= (found && w_cfg) ? w_tgt[23:16] : 8'd0;
        if (!found)
          rsp_addr <= '0;
        else if (w_cfg)
          rsp_addr <= ADDR_W'(a64[CFG_OFF_W-1:0]);
        else
          rsp_addr <= ADDR_W'(mem_addr);
      end
    end
  end
endmodule

// File: rtl/addr_window_xlate_chk.sv
module addr_window_xlate_chk #(
  parameter int NUM_WIN   = 16,
  parameter int ADDR_W    = 64,
  parameter int CFG_OFF_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_miss,
  input logic              rsp_cfg,
  input logic [(NUM_WIN>1 ? $clog2(NUM_WIN) : 1)-1:0] rsp_win,
  input logic [ADDR_W-1:0] rsp_addr
);
  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_win) && $stable(rsp_miss) && $stable(rsp_cfg)); // R9
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> !rsp_cfg && rsp_addr == '0); // R6
  AST_CFG_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cfg |-> (rsp_addr >> CFG_OFF_W) == '0); // R8
  AST_SELECTOR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 12'h900 |-> reg_rdata[30:4] == 27'd0); // R1
endmodule

bind addr_window_xlate addr_window_xlate_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .CFG_OFF_W(CFG_OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_miss(rsp_miss), .rsp_cfg(rsp_cfg),
  .rsp_win(rsp_win), .rsp_addr(rsp_addr)
);

// File: tb/addr_window_xlate_test.sv
`timescale 1ns/1ps
module addr_window_xlate_test;
  localparam int NW = 4;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready, req_inbound = 0;
  logic [63:0] req_addr = 0;
  logic rsp_valid, rsp_ready = 1, rsp_miss, rsp_cfg;
  logic [1:0] rsp_win;
  logic [63:0] rsp_addr;
  logic [7:0] rsp_bus, rsp_devfn;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_window_xlate #(.NUM_WIN(NW), .ADDR_W(64), .CFG_OFF_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_inbound(req_inbound), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_miss(rsp_miss),
    .rsp_cfg(rsp_cfg), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
    .rsp_bus(rsp_bus), .rsp_devfn(rsp_devfn));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic look(input bit inb, input logic [63:0] a);
    @(negedge clk); req_valid = 1; req_inbound = inb; req_addr = a;
    @(posedge clk); #1; req_valid = 0;
  endtask

  task automatic exp_mem(input bit inb, input logic [63:0] a, input int w, input logic [63:0] e, input string tag);
    look(inb, a);
    chk(rsp_valid && !rsp_miss && !rsp_cfg, {tag, " kind"}, {61'd0, rsp_valid, rsp_miss, rsp_cfg}, 64'h4);
    chk(rsp_win == 2'(w), {tag, " win"}, 64'(rsp_win), 64'(w));
    chk(rsp_addr == e, {tag, " addr"}, rsp_addr, e);
  endtask

  task automatic exp_miss(input bit inb, input logic [63:0] a, input string tag);
    look(inb, a);
    chk(rsp_valid && rsp_miss && !rsp_cfg && rsp_addr == 0, {tag, " miss"},
        {61'd0, rsp_valid, rsp_miss, rsp_cfg}, 64'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 reset state
    chk(rsp_valid == 0 && req_ready == 1, "R4 idle after reset", {62'd0, rsp_valid, req_ready}, 64'h1);
    rd(12'h900, 32'h0, "R1 selector reset");
    rd(12'h914, 32'hFFFF_FFFF, "R4 limit reset");
    rd(12'h908, 32'h0, "R4 outbound0 disabled");
    wr(12'h900, 32'h8000_0000);
    rd(12'h900, 32'h8000_0000, "R1 selector inbound");
    rd(12'h908, 32'h8000_0000, "R4 inbound0 enabled");
    exp_mem(1, 64'h9ABC_DEF0, 0, 64'h9ABC_DEF0, "R4 inbound default pass");
    exp_miss(1, 64'h1_0000_0000, "R5 above 32-bit limit");
    exp_miss(0, 64'h100, "R4 outbound empty");

    // R3 staging
    wr(12'h900, 32'h0000_0001);
    wr(12'h90C, 32'h1000); wr(12'h914, 32'h1FFF);
    wr(12'h918, 32'h0); wr(12'h91C, 32'hA); wr(12'h904, 32'h0);
    exp_miss(0, 64'h1800, "R3 not yet committed");
    wr(12'h908, 32'h8000_0000);
    exp_mem(0, 64'h1800, 1, 64'hA_0000_0800, "R7 translate");
    exp_mem(0, 64'h1000, 1, 64'hA_0000_0000, "R5 base edge");
    exp_mem(0, 64'h1FFF, 1, 64'hA_0000_0FFF, "R5 limit edge");
    exp_miss(0, 64'h0FFF, "R5 below base");
    exp_miss(0, 64'h2000, "R5 above limit");
    wr(12'h90C, 32'h5000);
    exp_mem(0, 64'h1800, 1, 64'hA_0000_0800, "R3 staged base ignored");
    rd(12'h90C, 32'h5000, "R2 staged base readback");
    rd(12'h91C, 32'hA, "R2 target high readback");
    rd(12'h900, 32'h1, "R1 index readback");

    // R7 sweep over all outbound windows
    for (int i = 0; i < NW; i++) begin
      wr(12'h900, 32'(i));
      wr(12'h90C, 32'(i * 32'h10000)); wr(12'h910, 32'h0);
      wr(12'h914, 32'(i * 32'h10000 + 32'hFFFF));
      wr(12'h918, 32'h8000_0000 + 32'(i * 32'h10_0000)); wr(12'h91C, 32'h0);
      wr(12'h904, 32'h0); wr(12'h908, 32'h8000_0000);
    end
    for (int k = 0; k < 32'h40000; k += 32'h1F3) begin
      int w;
      w = k >> 16;
      exp_mem(0, 64'(k), w, 64'h8000_0000 + 64'(w) * 64'h10_0000 + 64'(k - w * 32'h10000), "R7 sweep");
    end
    exp_miss(0, 64'h40000, "R5 sweep end");

    // R6 priority
    wr(12'h900, 32'h3);
    wr(12'h90C, 32'h0); wr(12'h914, 32'hFFFF_FFFF);
    wr(12'h918, 32'h0); wr(12'h91C, 32'h5000); wr(12'h908, 32'h8000_0000);
    exp_mem(0, 64'h25000, 2, 64'h8020_5000, "R6 lowest index wins");
    exp_mem(0, 64'h7000_0000, 3, 64'h5000_7000_0000, "R6 only wide window");

    // R8 configuration window
    wr(12'h900, 32'h8000_0000); wr(12'h908, 32'h0);
    exp_miss(1, 64'h9ABC, "R3 inbound0 disabled");
    wr(12'h900, 32'h8000_0001);
    wr(12'h904, 32'h4); wr(12'h90C, 32'h4000_0000); wr(12'h914, 32'h4FFF_FFFF);
    wr(12'h918, 32'h0312_0000); wr(12'h908, 32'h8000_0000);
    look(1, 64'h4000_1ABC);
    chk(rsp_valid && rsp_cfg && !rsp_miss, "R8 cfg kind", {62'd0, rsp_cfg, rsp_miss}, 64'h2);
    chk(rsp_bus == 8'h03, "R8 bus", 64'(rsp_bus), 64'h03);
    chk(rsp_devfn == 8'h12, "R8 devfn", 64'(rsp_devfn), 64'h12);
    chk(rsp_addr == 64'hABC, "R8 offset", rsp_addr, 64'hABC);
    chk(rsp_win == 2'd1, "R8 win", 64'(rsp_win), 64'd1);
    rd(12'h904, 32'h4, "R2 type readback");
    exp_miss(1, 64'h5000_0000, "R5 cfg window end");

    // R5 upper base extends limit
    wr(12'h900, 32'h0);
    wr(12'h90C, 32'h0); wr(12'h910, 32'h2); wr(12'h914, 32'hFFFF); wr(12'h908, 32'h8000_0000);
    exp_mem(0, 64'h2_0000_8000, 0, 64'h8000_8000, "R5 upper base hit");
    exp_miss(0, 64'h2_0001_0000, "R5 upper base above");

    // R2 index out of range
    wr(12'h900, 32'h7);
    wr(12'h90C, 32'h1234);
    rd(12'h90C, 32'h0, "R2 out-of-range read zero");
    wr(12'h908, 32'h8000_0000);
    wr(12'h900, 32'h3);
    rd(12'h90C, 32'h0, "R2 out-of-range write ignored");

    // R9 backpressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_inbound = 0; req_addr = 64'h10010;
    @(posedge clk); #1;
    chk(rsp_valid && !req_ready, "R9 stall ready low", {62'd0, rsp_valid, req_ready}, 64'h2);
    @(negedge clk); req_addr = 64'h20020;
    @(posedge clk); #1;
    chk(rsp_addr == 64'h8010_0010, "R9 held result", rsp_addr, 64'h8010_0010);
    @(negedge clk); rsp_ready = 1;
    @(posedge clk); #1; req_valid = 0;
    chk(rsp_valid && rsp_addr == 64'h8020_0020 && rsp_win == 2'd2, "R9 next result", rsp_addr, 64'h8020_0020);
    @(posedge clk); #1;
    chk(!rsp_valid, "R9 drained", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule